// File: doc/BRIEF.md
# Spread-Spectrum Phase-Jump Modulator

This block tells a multiphase clock selector how many single-phase steps to skip in each phase-detector comparison period. Zero steps leaves the synthesised clock at its nominal frequency. Three steps per period pulls it down by exactly 5000 ppm. The block sweeps a frequency-offset profile shaped as a triangle across that downward-only range. A noise-shaping quantiser turns the fractional profile value into an integer step count from 0 to 3 for each period. The integer counts alternate from period to period so that their running average follows the profile. The downstream loop filter smooths the remaining high-frequency quantisation noise.

The block runs on the 25 MHz reference clock, and one comparison period equals one reference cycle. The triangle lasts 825 reference cycles (33 µs). The profile value is computed incrementally, with one fixed step per cycle, so no table or multiplier is needed. The quantiser is second-order error feedback by default. A parameter selects a first-order accumulator instead. Dropping the enable clears the sweep position and all quantiser memory, and the output falls to zero steps. The next enable starts the sweep again from the bottom of the triangle.

Top module: `ssjump_mod`

## Requirements
- R1: One cycle after a rising clock edge that sees `enable` low (and throughout reset), `jump` is 0 and `valid` is 0.
- R2: Every rising edge that sees `enable` high produces `valid` = 1 with a fresh `jump` value in the following cycle. Comparison period and reference cycle coincide, so `valid` stays high as long as `enable` stays high.
- R3: The profile index k follows the sequence 0,1,…,411 and then 412,411,…,1,0, and repeats with a period of 825 edges. The profile value is x = k·477 in units of 2^-16 jump, with 477 = floor(3·65536/412). The peak 196524 never exceeds 3·65536. The first enabled edge uses k = 0.
- R4: With ORDER = 2, each enabled edge forms v = x + 2·e1 − e2, where e1 and e2 are the stored errors of the last two edges (zero after enable). The output `jump` = floor(v / 65536).
- R5: When floor(v / 65536) lies below 0 it is clamped to 0. When it lies above 3 it is clamped to 3.
- R6: The new stored error is v − jump·65536, saturated to the range [−65536, 131071].
- R7: With ORDER = 1 (v = x + e1), the step total over the first 825 enabled cycles is 1235, which is floor of the profile sum 80967888 / 65536. Every following period totals 1235 or 1236.
- R8: Dropping `enable` and raising it again restarts both the profile and the quantiser, so the output sequence repeats the sequence seen after the first enable.
- R9: If `enable` falls on the very edge where the profile would wrap from the end of the down-ramp back to k = 0, the output is still 0 on the next cycle, and the restart follows R8.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock; one edge per comparison period |
| rst_n | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Spreading enabled when high; low forces nominal frequency and clears state |
| jump | output | 2 | Number of single-phase steps for the current comparison period (0 to 3) |
| valid | output | 1 | High in each cycle that carries a new step count |

## Verification
The stress case is a disable that lands on the same edge as the profile wrap, where the sweep position would otherwise go from the final down-ramp cycle back to zero. The bench runs exactly 824 outputs, lowers `enable` in the next cycle so that the 825th edge sees it low, and expects a zero step with `valid` low instead of the wrap value. It then re-enables and compares against a quantiser model restarted from zero. The same bench also crosses the quantiser clamp and the error saturation near both ends of the triangle, and tags each mismatch there by which rule was active.

// File: rtl/ssjump_pkg.sv
package ssjump_pkg;

    // Which way the profile moves on the coming edge.
    typedef enum logic [1:0] {
        SEG_IDLE = 2'd0,
        SEG_RISE = 2'd1,
        SEG_FALL = 2'd2,
        SEG_WRAP = 2'd3
    } seg_e;

    function automatic seg_e seg_of(input logic run, input logic at_end, input logic rising);
        if (!run)        return SEG_IDLE;
        else if (at_end) return SEG_WRAP;
        else if (rising) return SEG_RISE;
        else             return SEG_FALL;
    endfunction

endpackage

// File: rtl/ssjump_profile.sv
module ssjump_profile
    import ssjump_pkg::*;
#(
    parameter int RAMP_LEN = 412,
    parameter int STEP     = 477,
    parameter int PH_W     = 10,
    parameter int X_W      = 18
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            run,
    output logic [PH_W-1:0] phase,
    output logic [X_W-1:0]  level
);

    localparam int LAST = 2 * RAMP_LEN;

    typedef struct packed {
        logic [PH_W-1:0] phase;
        logic [X_W-1:0]  level;
    } prof_t;

    prof_t st_d, st_q;
    seg_e  seg;

    always_comb begin
        seg  = seg_of(run, st_q.phase == PH_W'(LAST), st_q.phase < PH_W'(RAMP_LEN));
        st_d = st_q;
        unique case (seg)
            SEG_IDLE: st_d = '0;
            SEG_WRAP: st_d = '0;
            SEG_RISE: begin
                st_d.phase = st_q.phase + PH_W'(1);
                st_d.level = st_q.level + X_W'(STEP);
            end
            SEG_FALL: begin
                st_d.phase = st_q.phase + PH_W'(1);
                st_d.level = st_q.level - X_W'(STEP);
            end
            default: st_d = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign phase = st_q.phase;
    assign level = st_q.level;

endmodule

// File: rtl/ssjump_shaper.sv
module ssjump_shaper #(
    parameter int ORDER    = 2,
    parameter int FRAC_W   = 16,
    parameter int X_W      = 18,
    parameter int JUMP_W   = 2,
    parameter int MAX_JUMP = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic [X_W-1:0]    level,
    output logic [JUMP_W-1:0] jump,
    output logic              valid
);

    localparam int E_W = FRAC_W + 3;
    localparam int V_W = FRAC_W + 5;
    localparam int ONE = 1 << FRAC_W;
    localparam logic signed [V_W-1:0] Q_MAX = V_W'(MAX_JUMP);
    localparam logic signed [V_W-1:0] E_LO  = -(V_W'(ONE));
    localparam logic signed [V_W-1:0] E_HI  = V_W'(2 * ONE - 1);

    typedef struct packed {
        logic [E_W-1:0]    e1;
        logic [E_W-1:0]    e2;
        logic [JUMP_W-1:0] jump;
        logic              valid;
    } shp_t;

    shp_t st_d, st_q;

    logic signed [V_W-1:0] fb;
    logic signed [V_W-1:0] v;
    logic signed [V_W-1:0] q;
    logic signed [V_W-1:0] y_scaled;
    logic signed [V_W-1:0] resid;
    logic [JUMP_W-1:0]     y;
    logic [E_W-1:0]        e_new;

    function automatic logic signed [V_W-1:0] sx(input logic [E_W-1:0] e);
        return {{(V_W-E_W){e[E_W-1]}}, e};
    endfunction

    // Error-feedback filter: the parameter picks the noise-shaping order.
    if (ORDER >= 2) begin : g_second
        always_comb fb = (sx(st_q.e1) <<< 1) - sx(st_q.e2);
    end else begin : g_first
        always_comb fb = sx(st_q.e1);
    end

    always_comb begin
        v = $signed({{(V_W-X_W){1'b0}}, level}) + fb;
        q = v >>> FRAC_W;
        if (q < 0)          y = '0;
        else if (q > Q_MAX) y = JUMP_W'(MAX_JUMP);
        else                y = q[JUMP_W-1:0];

        y_scaled = $signed({{(V_W-JUMP_W){1'b0}}, y}) <<< FRAC_W;
        resid    = v - y_scaled;
        if (resid < E_LO)      e_new = E_LO[E_W-1:0];
        else if (resid > E_HI) e_new = E_HI[E_W-1:0];
        else                   e_new = resid[E_W-1:0];

        if (!run) begin
            st_d = '0;
        end else begin
            st_d.e1    = e_new;
            st_d.e2    = st_q.e1;
            st_d.jump  = y;
            st_d.valid = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign jump  = st_q.jump;
    assign valid = st_q.valid;

endmodule

// File: rtl/ssjump_mod.sv
module ssjump_mod #(
    parameter int FRAC_W   = 16,
    parameter int RAMP_LEN = 412,
    parameter int MAX_JUMP = 3,
    parameter int ORDER    = 2,
    localparam int JUMP_W  = $clog2(MAX_JUMP + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    output logic [JUMP_W-1:0] jump,
    output logic              valid
);

    localparam int PERIOD = 2 * RAMP_LEN + 1;
    localparam int PH_W   = $clog2(PERIOD);
    localparam int ONE    = 1 << FRAC_W;
    localparam int STEP   = (MAX_JUMP * ONE) / RAMP_LEN;
    localparam int X_W    = FRAC_W + JUMP_W;

    logic [PH_W-1:0] prof_phase;
    logic [X_W-1:0]  prof_level;

    ssjump_profile #(
        .RAMP_LEN (RAMP_LEN),
        .STEP     (STEP),
        .PH_W     (PH_W),
        .X_W      (X_W)
    ) u_profile (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (enable),
        .phase (prof_phase),
        .level (prof_level)
    );

    ssjump_shaper #(
        .ORDER    (ORDER),
        .FRAC_W   (FRAC_W),
        .X_W      (X_W),
        .JUMP_W   (JUMP_W),
        .MAX_JUMP (MAX_JUMP)
    ) u_shaper (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (enable),
        .level (prof_level),
        .jump  (jump),
        .valid (valid)
    );

endmodule

// File: rtl/ssjump_mod_chk.sv
module ssjump_mod_chk #(
    parameter int RAMP_LEN = 412,
    parameter int STEP     = 477,
    parameter int PH_W     = 10,
    parameter int X_W      = 18,
    parameter int JUMP_W   = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              enable,
    input logic [JUMP_W-1:0] jump,
    input logic              valid,
    input logic [PH_W-1:0]   prof_phase,
    input logic [X_W-1:0]    prof_level
);

    localparam int PERIOD = 2 * RAMP_LEN + 1;

    // R1: disabled edge yields zero steps and no strobe
    p_idle_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (jump == '0 && !valid));

    // R2: every enabled edge delivers one strobe
    p_strobe_each_period_r2: assert property (@(posedge clk) disable iff (!rst_n)
        enable |=> valid);

    // R3: sweep position stays inside one triangle period
    p_phase_in_period_r3: assert property (@(posedge clk) disable iff (!rst_n)
        prof_phase < PH_W'(PERIOD));

    // R3: bottom of the triangle is zero offset
    p_bottom_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        prof_phase == '0 |-> prof_level == '0);

    // R3: peak of the triangle
    p_peak_value_r3: assert property (@(posedge clk) disable iff (!rst_n)
        prof_phase == PH_W'(RAMP_LEN) |-> prof_level == X_W'(RAMP_LEN * STEP));

    // R3: rising ramp grows by one step per cycle
    p_rise_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (prof_phase != '0 && prof_phase <= PH_W'(RAMP_LEN))
            |-> prof_level == $past(prof_level) + X_W'(STEP));

    // R3: falling ramp shrinks by one step per cycle
    p_fall_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        prof_phase > PH_W'(RAMP_LEN)
            |-> prof_level == $past(prof_level) - X_W'(STEP));

endmodule

bind ssjump_mod ssjump_mod_chk #(
    .RAMP_LEN (RAMP_LEN),
    .STEP     (STEP),
    .PH_W     (PH_W),
    .X_W      (X_W),
    .JUMP_W   (JUMP_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .enable     (enable),
    .jump       (jump),
    .valid      (valid),
    .prof_phase (prof_phase),
    .prof_level (prof_level)
);

// File: tb/tb_ssjump_mod.sv
module tb_ssjump_mod;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       enable = 1'b0;
    logic [1:0] jump, jump_o1;
    logic       valid, valid_o1;

    int  n_checks = 0;
    int  n_fails  = 0;
    bit  done     = 0;

    longint m_e1, m_e2, m_o1;
    int     sat_age;

    always #2.5 clk = ~clk;

    ssjump_mod dut (
        .clk (clk), .rst_n (rst_n), .enable (enable), .jump (jump), .valid (valid)
    );

    ssjump_mod #(.ORDER(1)) dut_o1 (
        .clk (clk), .rst_n (rst_n), .enable (enable), .jump (jump_o1), .valid (valid_o1)
    );

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    // R3 profile, computed from the index sequence
    function automatic longint prof_x(input int n);
        int p = n % 825;
        int k = (p < 412) ? p : 824 - p;
        return longint'(k) * 477;
    endfunction

    function automatic longint sat_e(input longint r, output bit hit);
        hit = 1'b0;
        if (r < -65536) begin hit = 1'b1; return -65536; end
        if (r > 131071) begin hit = 1'b1; return 131071; end
        return r;
    endfunction

    task automatic models_clear();
        m_e1 = 0; m_e2 = 0; m_o1 = 0; sat_age = 99;
    endtask

    // R4/R5/R6 second-order recurrence; returns the tag to blame
    task automatic model2(input longint x, output longint y, output string tag);
        longint v = x + 2 * m_e1 - m_e2;
        longint q = v >>> 16;
        bit clamped = (q < 0) || (q > 3);
        bit hit;
        y = (q < 0) ? 0 : ((q > 3) ? 3 : q);
        m_e2 = m_e1;
        m_e1 = sat_e(v - y * 65536, hit);
        if (hit) sat_age = 0; else sat_age++;
        if (clamped)          tag = "R5";
        else if (sat_age < 3) tag = "R6";
        else                  tag = "R4";
    endtask

    task automatic model1(input longint x, output longint y);
        longint v = x + m_o1;
        longint q = v >>> 16;
        bit hit;
        y = (q < 0) ? 0 : ((q > 3) ? 3 : q);
        m_o1 = sat_e(v - y * 65536, hit);
    endtask

    // Enabled run of n outputs compared against the models; the first
    // output sampled corresponds to k = 0. Returns per-period order-1 sums.
    task automatic run_compare(input int n, input string rtag, output int sum_a, output int sum_b);
        longint y2, y1;
        string  tag;
        sum_a = 0; sum_b = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            model2(prof_x(i), y2, tag);
            model1(prof_x(i), y1);
            check(valid == 1'b1, {rtag, " R2 strobe"}, valid, 1);
            check(jump == y2[1:0], {rtag, " ", tag, " jump"}, jump, y2);
            check(jump_o1 == y1[1:0], {rtag, " R3 first-order track"}, jump_o1, y1);
            if (i < 825) sum_a += int'(jump_o1);
            else if (i < 1650) sum_b += int'(jump_o1);
        end
    endtask

    task automatic expect_idle(input int cycles, input string tag);
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            check(jump == 2'd0 && valid == 1'b0, {tag, " idle second-order"}, {jump, valid}, 0);
            check(jump_o1 == 2'd0 && valid_o1 == 1'b0, {tag, " idle first-order"}, {jump_o1, valid_o1}, 0);
        end
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        check(jump == 2'd0 && valid == 1'b0, "R1 in reset", {jump, valid}, 0);
        rst_n = 1'b1;
        expect_idle(4, "R1 after reset");
    endtask

    task automatic t_sweep();
        int sa, sb;
        models_clear();
        enable = 1'b1;
        run_compare(1650, "R3", sa, sb);
        check(sa == 1235, "R7 first period total", sa, 1235);
        check(sb == 1235 || sb == 1236, "R7 second period total", sb, 1235);
    endtask

    task automatic t_disable_mid();
        int sa, sb;
        enable = 1'b0;
        expect_idle(5, "R1 mid-sweep disable");
        models_clear();
        enable = 1'b1;
        run_compare(600, "R8 restart", sa, sb);
    endtask

    task automatic t_disable_at_wrap();
        int sa, sb;
        enable = 1'b0;
        expect_idle(2, "R1 gap");
        models_clear();
        enable = 1'b1;
        run_compare(824, "R9 lead-in", sa, sb);
        enable = 1'b0;                 // 825th edge (the wrap edge) sees it low
        expect_idle(3, "R9 disable on wrap");
        models_clear();
        enable = 1'b1;
        run_compare(60, "R9 restart", sa, sb);
        enable = 1'b0;
        expect_idle(1, "R1 final");
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_checks++;
            n_fails++;
            $display("FAIL R2 watchdog: actual 100000 cycles expected completion sooner");
            summary();
            $finish;
        end
    end

    initial begin
        t_reset();
        t_sweep();
        t_disable_mid();
        t_disable_at_wrap();
        if (!done) begin
            done = 1;
            summary();
            $finish;
        end
    end

endmodule